// File: doc/BRIEF.md
# NAND Sector Hamming Syndrome Classifier and Bit Repairer

This block checks one 512-byte NAND sector that is protected by a 3-byte Hamming code. It receives two codes. One is the code read back from the spare area. The other is the code recomputed over the data just read. Each code is unpacked into a wide word, and the two words are XORed to form a syndrome. The block counts the set bits of the syndrome and sorts the result into four classes: clean, a single data-bit error that can be fixed, damage confined to the code itself, or an error that cannot be fixed. For a fixable error, the upper half of the syndrome gives the byte offset and the bit index of the faulty bit.

Code pairs enter over a valid/ready handshake. The verdict comes back on a registered valid/ready output, and a new pair can be taken on every cycle. A side port lets the surrounding logic present any sector byte together with its offset. The byte comes back with the faulty bit flipped when the offset matches the reported error location, and unchanged otherwise. Generating parity over the data stream, buffering the sector and any register access are left to other logic.

Top module: `nand_ecc_fixer`

## Requirements
- R1: Each 24-bit code port carries three bytes: byte0 in [7:0], byte1 in [15:8], byte2 in [23:16]. The code is unpacked into a 28-bit word with byte0 at bits 7:0, byte2[3:0] at bits 11:8, byte1 at bits 23:16 and byte2[7:4] at bits 27:24. Bits 15:12 are zero.
- R2: When the two codes are equal, the syndrome is zero and the status is 0 (clean), with byte_addr and bit_idx both 0.
- R3: When the syndrome has exactly 12 set bits, the status is 1 (corrected). bit_idx is syndrome bits 18:16 and byte_addr is syndrome bits 27:19, whatever the pattern of the lower bits.
- R4: When the syndrome has exactly one set bit, the status is 2 (code field error), with byte_addr and bit_idx both 0.
- R5: Any other nonzero count of set bits (2 to 11, or 13 to 24) gives status 3 (uncorrectable), with byte_addr and bit_idx both 0.
- R6: The result appears on status, byte_addr and bit_idx, with out_valid high, one clock edge after the edge on which in_valid and in_ready are both high.
- R7: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the outputs hold their values.
- R8: fix_out equals fix_in XOR (1 << bit_idx) only when out_valid is high, the status is 1 and fix_addr equals byte_addr. In every other case fix_out equals fix_in.
- R9: While reset is held and right after it, out_valid is 0, in_ready is 1 and the status is 0.
- R10: With out_ready held high, code pairs presented on consecutive cycles are each accepted, and each result appears on the cycle after its pair was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A code pair is present |
| in_ready | output | 1 | The block can take a code pair |
| stored_code | input | 24 | Code read from the spare area, packed as in R1 |
| calc_code | input | 24 | Code recomputed over the data, packed as in R1 |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| status | output | 2 | 0 clean, 1 corrected, 2 code field error, 3 uncorrectable |
| byte_addr | output | 9 | Offset of the faulty byte (status 1 only) |
| bit_idx | output | 3 | Index of the faulty bit in that byte (status 1 only) |
| fix_addr | input | 9 | Offset of the byte presented on fix_in |
| fix_in | input | 8 | Sector byte to repair |
| fix_out | output | 8 | fix_in with the faulty bit flipped when it applies |

## Verification
Some properties are checked on every cycle. Outputs stay stable under backpressure, and an accepted pair always yields a valid result on the next edge. The location fields are zero whenever the status is not 1. The repair port never changes more than one bit and never changes anything outside a corrected result. Equal codes always give a clean status, and in_ready stays high while no result is pending. Other behaviour can only be shown by the bench's scenarios. These are the exact class chosen for each count of set bits at the edges (1, 2, 11, 12, 13 and 24), the exact unpacking of the three bytes into offset and bit, a count of 12 that does not follow the complement pattern, and pairs accepted back-to-back.

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer #(
  parameter int PAIRS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] stored_code,
  input  logic [23:0] calc_code,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  status,
  output logic [8:0]  byte_addr,
  output logic [2:0]  bit_idx,
  input  logic [8:0]  fix_addr,
  input  logic [7:0]  fix_in,
  output logic [7:0]  fix_out
);
  localparam int CODE_W = 24;
  localparam int WORD_W = 28;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_FIXED = 2'd1;
  localparam logic [1:0] ST_CODE  = 2'd2;
  localparam logic [1:0] ST_BAD   = 2'd3;

  function automatic logic [WORD_W-1:0] unpack(input logic [CODE_W-1:0] c);
    return {c[23:20], c[15:8], 4'b0000, c[19:16], c[7:0]};
  endfunction

  function automatic logic [CNT_W-1:0] ones(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < WORD_W; i++) s = s + CNT_W'(w[i]);
    return s;
  endfunction

  logic [WORD_W-1:0] syn;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        cls;
  logic              take;

  assign syn  = unpack(stored_code) ^ unpack(calc_code);
  assign cnt  = ones(syn);
  assign in_ready = !out_valid || out_ready;
  assign take = in_valid && in_ready;

  always_comb begin
    if (syn == '0)                   cls = ST_CLEAN;
    else if (cnt == CNT_W'(PAIRS))   cls = ST_FIXED;
    else if (cnt == CNT_W'(1))       cls = ST_CODE;
    else                             cls = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      status    <= ST_CLEAN;
      byte_addr <= '0;
      bit_idx   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      status    <= cls;
      byte_addr <= (cls == ST_FIXED) ? syn[27:19] : '0;
      bit_idx   <= (cls == ST_FIXED) ? syn[18:16] : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign fix_out = (out_valid && status == ST_FIXED && fix_addr == byte_addr)
                   ? (fix_in ^ (8'd1 << bit_idx)) : fix_in;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(status) && $stable(byte_addr) && $stable(bit_idx));

  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  equal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && stored_code == calc_code |=> status == ST_CLEAN);

  // R5
  loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && status != ST_FIXED |-> byte_addr == '0 && bit_idx == '0);

  // R8
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fix_out ^ fix_in) <= 1);

  // R8
  no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && status == ST_FIXED) |-> fix_out == fix_in);
endmodule

// File: tb/sim_nand_ecc_fixer.sv
`timescale 1ns/1ps
module sim_nand_ecc_fixer;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic in_ready, out_valid;
  logic [1:0] status;
  logic [8:0] byte_addr;
  logic [2:0] bit_idx;
  logic [8:0] fix_addr = '0;
  logic [7:0] fix_in = '0, fix_out;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  nand_ecc_fixer u0 (.*);

  // stored, calc, status, byte, bit
  localparam int NV = 13;
  localparam logic [61:0] VEC [NV] = '{
    {24'h123456, 24'h123456, 2'd0, 9'd0,   3'd0},  // R2
    {24'h000000, 24'h0F00FF, 2'd1, 9'd0,   3'd0},  // R3
    {24'h000000, 24'hF0FF00, 2'd1, 9'd511, 3'd7},  // R3
    {24'h000000, 24'hA5AA55, 2'd1, 9'd341, 3'd2},  // R1
    {24'h000000, 24'h1E55AA, 2'd1, 9'd42,  3'd5},  // R1
    {24'h3C5A96, 24'h335A69, 2'd1, 9'd0,   3'd0},  // R3
    {24'h5A5A5A, 24'h5A5B5A, 2'd2, 9'd0,   3'd0},  // R4
    {24'h800000, 24'h000000, 2'd2, 9'd0,   3'd0},  // R4
    {24'h000003, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5
    {24'h0F00FE, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5
    {24'h0F01FF, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5
    {24'hFFFFFF, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5
    {24'h000FFF, 24'h000000, 2'd1, 9'd1,   3'd7}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input logic [61:0] v);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " status"}, {30'd0, status}, {30'd0, v[13:12]});
    check({req, " byte"}, {23'd0, byte_addr}, {23'd0, v[11:3]});
    check({req, " bit"}, {29'd0, bit_idx}, {29'd0, v[2:0]});
  endtask

  task automatic present(input logic [61:0] v);
    in_valid = 1; stored_code = v[61:38]; calc_code = v[37:14];
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    #35;
    check("R9 valid", {31'd0, out_valid}, 0);
    check("R9 ready", {31'd0, in_ready}, 1);
    check("R9 status", {30'd0, status}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 after", {31'd0, out_valid}, 0);

    // table walk, one pair at a time
    out_ready = 1;
    for (int i = 0; i < NV; i++) begin
      present(VEC[i]);
      @(negedge clk);
      in_valid = 0;
      check_res($sformatf("R6 vec%0d", i), VEC[i]);
    end
    @(negedge clk);
    check("R6 drop", {31'd0, out_valid}, 0);

    // R8 repair port, with a corrected result held under backpressure
    out_ready = 0;
    present(VEC[3]);
    @(negedge clk);
    in_valid = 0;
    check("R7 ready low", {31'd0, in_ready}, 0);
    fix_addr = 9'd341; fix_in = 8'h00;
    #1 check("R8 flip", {24'd0, fix_out}, 32'h04);
    fix_in = 8'hFF;
    #1 check("R8 flip hi", {24'd0, fix_out}, 32'hFB);
    fix_addr = 9'd340;
    #1 check("R8 addr miss", {24'd0, fix_out}, 32'hFF);

    // R7 backpressure: second pair waits
    present(VEC[8]);
    @(negedge clk);
    check_res("R7 held", VEC[3]);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check_res("R7 next", VEC[8]);
    fix_addr = 9'd0; fix_in = 8'h5A;
    #1 check("R8 no fix on st3", {24'd0, fix_out}, 32'h5A);

    // R8 code-field error at address 0 must not flip
    present(VEC[7]);
    @(negedge clk);
    in_valid = 0;
    #1 check("R8 no fix on st2", {24'd0, fix_out}, 32'h5A);
    @(negedge clk);

    // R10 back-to-back acceptance
    present(VEC[2]);
    @(negedge clk);
    check("R10 ready", {31'd0, in_ready}, 1);
    check_res("R10 a", VEC[2]);
    present(VEC[4]);
    @(negedge clk);
    check_res("R10 b", VEC[4]);
    present(VEC[12]);
    @(negedge clk);
    in_valid = 0;
    check_res("R10 c", VEC[12]);
    fix_addr = 9'd1; fix_in = 8'h00;
    #1 check("R8 odd shape", {24'd0, fix_out}, 32'h80);

    // R9 reset mid-stream
    out_ready = 0;
    present(VEC[6]);
    @(negedge clk);
    in_valid = 0;
    rst_n = 0;
    #1 check("R9 async", {31'd0, out_valid}, 0);
    check("R9 status", {30'd0, status}, 0);
    check("R9 fix idle", {24'd0, fix_out}, 32'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule